// File: doc/BRIEF.md
# Host-Card Message Mailbox Register Block

This block sits on the card side of a small programmed-I/O window of eight byte addresses. Through it the host and the card core pass messages to each other. The block holds a shared data word, a status byte, a control byte and an interrupt-routing byte. The status byte carries two independent three-bit handshake fields, one for each direction. The host and the core both advance these fields, and each side polls them to pace a message transfer.

Control writes from the host become single-cycle event pulses toward the core. A pulse fires when the host clears the transmit or receive notify bit and then sets it again. The control byte also holds a level that keeps the core in reset and a flag that enables 16-bit data access.

The core can request a host interrupt. The request is latched as pending and is driven onto one of several host interrupt lines, chosen by the interrupt-routing byte. Any host read of the end-of-interrupt address retires the pending request.

Top module: `mbx_regs`

## Requirements
- R1: After synchronous reset, every readable address returns zero, both handshake fields are idle (0), no host interrupt line is driven, no event pulse is active and the core reset output is low.
- R2: The register addresses are data low byte 0, data high byte 1, status 2, control 4, end-of-interrupt 5 and interrupt-routing 6. Control keeps only bits 5:0 and reads zero above them. Interrupt-routing keeps only bit 4 (enable) and bits 2:0 (line number). All other bits read zero.
- R3: The status byte is laid out as bit 7 wake flag, bits 6:4 receive state, bit 3 clear-NAK flag and bits 2:0 transmit state. Host writes read back unchanged. A core-side write of either field updates only that field.
- R4: The handshake codes are 0 idle, 1 high-length available, 2 high-length accepted, 3 transfer complete, 4 transferring, 5 error, 6 low-length available and 7 low-length accepted. `rx_ready` is high exactly when the receive field holds 1, 5 or 6.
- R5: A host write that changes control bit 1 (transmit notify) or bit 0 (receive notify) from 0 to 1 raises `ev_txint` or `ev_rxint` for exactly one cycle, in the cycle after the write. A write that leaves the bit at 1, or that clears it, raises no pulse.
- R6: `core_rst` follows control bit 4, and `wide_mode` follows control bit 5, from the cycle after the write.
- R7: `c_irq_req` sets a pending request. While the request is pending and the enable bit is set, exactly the host line selected by bits 2:0 is high. With the enable bit clear, no line is driven, and the request stays pending.
- R8: A host read of address 5 raises `eoi_pulse` for one cycle in the following cycle and clears the pending request. A host read of that address returns zero.
- R9: When the host and the core write status in the same cycle, a field the host changes takes the host's value. A field the host writes back unchanged takes the core's value.
- R10: With `wide_mode` set, a wide access at address 0 writes or reads both data bytes in one cycle, with the low byte at the even address. Without `wide_mode`, a wide write at address 0 updates only the low byte and a wide read returns only the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 3 | Host byte address within the window |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wide | input | 1 | Host access is 16 bits wide |
| h_wdata | input | 16 | Host write data, low byte used for byte access |
| h_rdata | output | 16 | Host read data for the addressed register |
| c_tx_we | input | 1 | Core writes the transmit handshake field |
| c_tx_state | input | 3 | New transmit handshake code |
| c_rx_we | input | 1 | Core writes the receive handshake field |
| c_rx_state | input | 3 | New receive handshake code |
| c_data_we | input | 1 | Core writes the data word |
| c_data | input | 16 | Core data word |
| data_q | output | 16 | Current data word |
| status_q | output | 8 | Current status byte |
| rx_ready | output | 1 | Receive field holds a code that needs service |
| ev_txint | output | 1 | One-cycle transmit-notify event to the core |
| ev_rxint | output | 1 | One-cycle receive-notify event to the core |
| core_rst | output | 1 | Holds the core in reset |
| wide_mode | output | 1 | 16-bit data access enabled |
| c_irq_req | input | 1 | Core requests a host interrupt |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |
| host_irq | output | 8 | Host interrupt lines, at most one high |

## Verification
A status register that merges the host and core writes in the wrong way shows up at once. On the next status read, one field holds a stale or foreign code, and `rx_ready` follows that wrong field in the same cycle. A control edge detector with a wrong history appears one cycle after the write: a pulse that is missing, a pulse that is repeated, or a pulse on a rewrite of a bit that is already set. A wrong pending or routing state appears on `host_irq` in the cycle after the request, the routing write or the end-of-interrupt read. It shows as a dark line, a wrong line or a line that stays high.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_STATUS  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd4;
    localparam logic [ADDR_W-1:0] A_EOI     = 3'd5;
    localparam logic [ADDR_W-1:0] A_ROUTE   = 3'd6;

    typedef enum logic [2:0] {
        HS_IDLE      = 3'd0,
        HS_HI_AVAIL  = 3'd1,
        HS_HI_ACCEPT = 3'd2,
        HS_DONE      = 3'd3,
        HS_MOVING    = 3'd4,
        HS_FAULT     = 3'd5,
        HS_LO_AVAIL  = 3'd6,
        HS_LO_ACCEPT = 3'd7
    } hs_state_e;

    // Bit order is the visible byte layout: 7 wake, 6:4 rx, 3 clear-NAK, 2:0 tx.
    typedef struct packed {
        logic      wake;
        hs_state_e rx;
        logic      clrnak;
        hs_state_e tx;
    } status_t;

    // Bits 5:0 of the control byte.
    typedef struct packed {
        logic       wide;
        logic       hold;
        logic [1:0] spare;
        logic       txn;
        logic       rxn;
    } ctrl_t;

    function automatic logic needs_service(hs_state_e s);
        return (s == HS_LO_AVAIL) || (s == HS_HI_AVAIL) || (s == HS_FAULT);
    endfunction

endpackage

// File: rtl/mbx_status.sv
module mbx_status
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_we,
    input  status_t   host_val,
    input  logic      core_tx_we,
    input  hs_state_e core_tx,
    input  logic      core_rx_we,
    input  hs_state_e core_rx,
    output status_t   stat
);
    status_t   nxt;
    logic      host_tx_change;
    logic      host_rx_change;

    always_comb begin
        host_tx_change = host_we && (host_val.tx != stat.tx);
        host_rx_change = host_we && (host_val.rx != stat.rx);
        nxt = stat;
        if (host_we) begin
            nxt.wake   = host_val.wake;
            nxt.clrnak = host_val.clrnak;
        end
        if (core_tx_we && !host_tx_change) nxt.tx = core_tx;
        else if (host_we)                   nxt.tx = host_val.tx;
        if (core_rx_we && !host_rx_change) nxt.rx = core_rx;
        else if (host_we)                   nxt.rx = host_val.rx;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ctrl_t wval,
    output ctrl_t ctrl,
    output logic  ev_tx,
    output logic  ev_rx
);
    ctrl_t prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            prev <= '0;
        end else begin
            prev <= ctrl;
            if (we) ctrl <= wval;
        end
    end

    assign ev_tx = ctrl.txn && !prev.txn;
    assign ev_rx = ctrl.rxn && !prev.rxn;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int IRQ_LINES = 8,
    localparam int LINE_W = (IRQ_LINES > 1) ? $clog2(IRQ_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 route_we,
    input  logic                 en_in,
    input  logic [LINE_W-1:0]    line_in,
    input  logic                 req,
    input  logic                 eoi_hit,
    output logic                 en,
    output logic [LINE_W-1:0]    line,
    output logic                 pending,
    output logic                 eoi,
    output logic [IRQ_LINES-1:0] lines
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            line    <= '0;
            pending <= 1'b0;
            eoi     <= 1'b0;
        end else begin
            if (route_we) begin
                en   <= en_in;
                line <= line_in;
            end
            pending <= req || (pending && !eoi_hit);
            eoi     <= eoi_hit;
        end
    end

    for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
        assign lines[i] = en && pending && (line == LINE_W'(i));
    end
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int IRQ_LINES = 8,
    localparam int LINE_W = (IRQ_LINES > 1) ? $clog2(IRQ_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2:0]           h_addr,
    input  logic                 h_wr,
    input  logic                 h_rd,
    input  logic                 h_wide,
    input  logic [15:0]          h_wdata,
    output logic [15:0]          h_rdata,
    input  logic                 c_tx_we,
    input  logic [2:0]           c_tx_state,
    input  logic                 c_rx_we,
    input  logic [2:0]           c_rx_state,
    input  logic                 c_data_we,
    input  logic [15:0]          c_data,
    output logic [15:0]          data_q,
    output logic [7:0]           status_q,
    output logic                 rx_ready,
    output logic                 ev_txint,
    output logic                 ev_rxint,
    output logic                 core_rst,
    output logic                 wide_mode,
    input  logic                 c_irq_req,
    output logic                 eoi_pulse,
    output logic [IRQ_LINES-1:0] host_irq
);
    status_t           stat;
    ctrl_t             ctrl_r;
    logic              route_en;
    logic [LINE_W-1:0] route_line;
    logic              irq_pending;

    logic st_we, ct_we, rt_we, lo_we, hi_we, eoi_hit, wide_acc;

    always_comb begin
        wide_acc = h_wide && ctrl_r.wide;
        st_we    = h_wr && (h_addr == A_STATUS);
        ct_we    = h_wr && (h_addr == A_CTRL);
        rt_we    = h_wr && (h_addr == A_ROUTE);
        lo_we    = h_wr && (h_addr == A_DATA_LO);
        hi_we    = h_wr && ((h_addr == A_DATA_HI) || ((h_addr == A_DATA_LO) && wide_acc));
        eoi_hit  = h_rd && (h_addr == A_EOI);
    end

    // Data word: the host has priority over the core for each byte lane.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            if (c_data_we) data_q <= c_data;
            if (lo_we) data_q[7:0] <= h_wdata[7:0];
            if (hi_we) data_q[15:8] <= (h_addr == A_DATA_HI) ? h_wdata[7:0] : h_wdata[15:8];
        end
    end

    mbx_status u_status (
        .clk        (clk),
        .rst        (rst),
        .host_we    (st_we),
        .host_val   (status_t'(h_wdata[7:0])),
        .core_tx_we (c_tx_we),
        .core_tx    (hs_state_e'(c_tx_state)),
        .core_rx_we (c_rx_we),
        .core_rx    (hs_state_e'(c_rx_state)),
        .stat       (stat)
    );

    mbx_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ct_we),
        .wval  (ctrl_t'(h_wdata[5:0])),
        .ctrl  (ctrl_r),
        .ev_tx (ev_txint),
        .ev_rx (ev_rxint)
    );

    mbx_irq #(.IRQ_LINES(IRQ_LINES)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .route_we (rt_we),
        .en_in    (h_wdata[4]),
        .line_in  (h_wdata[LINE_W-1:0]),
        .req      (c_irq_req),
        .eoi_hit  (eoi_hit),
        .en       (route_en),
        .line     (route_line),
        .pending  (irq_pending),
        .eoi      (eoi_pulse),
        .lines    (host_irq)
    );

    assign status_q  = stat;
    assign rx_ready  = needs_service(stat.rx);
    assign core_rst  = ctrl_r.hold;
    assign wide_mode = ctrl_r.wide;

    always_comb begin
        h_rdata = '0;
        case (h_addr)
            A_DATA_LO: h_rdata = wide_acc ? data_q : {8'h00, data_q[7:0]};
            A_DATA_HI: h_rdata = {8'h00, data_q[15:8]};
            A_STATUS:  h_rdata = {8'h00, stat};
            A_CTRL:    h_rdata = {10'd0, ctrl_r};
            A_ROUTE: begin
                h_rdata[4]          = route_en;
                h_rdata[LINE_W-1:0] = route_line;
            end
            default:   h_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int IRQ_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic [2:0]           h_addr,
    input logic                 h_wr,
    input logic                 h_rd,
    input logic [15:0]          h_wdata,
    input logic                 c_irq_req,
    input logic [7:0]           status_q,
    input logic                 rx_ready,
    input logic                 ev_txint,
    input logic                 ev_rxint,
    input logic                 core_rst,
    input logic                 eoi_pulse,
    input logic                 route_en,
    input logic                 txn_bit,
    input logic [IRQ_LINES-1:0] host_irq
);
    p_ev_single_r5: assert property (@(posedge clk) disable iff (rst)
        ev_txint |=> !ev_txint);
    p_ev_rise_r5: assert property (@(posedge clk) disable iff (rst)
        ev_txint |-> (txn_bit && !$past(txn_bit)));
    p_evrx_single_r5: assert property (@(posedge clk) disable iff (rst)
        ev_rxint |=> !ev_rxint);
    p_rx_ready_r4: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> (status_q[6:4] == 3'd1 || status_q[6:4] == 3'd5 || status_q[6:4] == 3'd6));
    p_hold_src_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> $past(h_wr && h_addr == 3'd4 && h_wdata[4]));
    p_irq_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(host_irq));
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !route_en |-> (host_irq == '0));
    p_eoi_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (h_rd && h_addr == 3'd5) |=> eoi_pulse);
    p_eoi_retire_r8: assert property (@(posedge clk) disable iff (rst)
        (h_rd && h_addr == 3'd5 && !c_irq_req) |=> (host_irq == '0));
endmodule

bind mbx_regs mbx_chk #(.IRQ_LINES(IRQ_LINES)) u_mbx_chk (
    .clk       (clk),
    .rst       (rst),
    .h_addr    (h_addr),
    .h_wr      (h_wr),
    .h_rd      (h_rd),
    .h_wdata   (h_wdata),
    .c_irq_req (c_irq_req),
    .status_q  (status_q),
    .rx_ready  (rx_ready),
    .ev_txint  (ev_txint),
    .ev_rxint  (ev_rxint),
    .core_rst  (core_rst),
    .eoi_pulse (eoi_pulse),
    .route_en  (route_en),
    .txn_bit   (ctrl_r.txn),
    .host_irq  (host_irq)
);

// File: tb/test_mbx_regs.sv
module test_mbx_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  h_addr = '0;
    logic        h_wr = 1'b0, h_rd = 1'b0, h_wide = 1'b0;
    logic [15:0] h_wdata = '0;
    logic [15:0] h_rdata;
    logic        c_tx_we = 1'b0, c_rx_we = 1'b0, c_data_we = 1'b0, c_irq_req = 1'b0;
    logic [2:0]  c_tx_state = '0, c_rx_state = '0;
    logic [15:0] c_data = '0;
    logic [15:0] data_q;
    logic [7:0]  status_q;
    logic        rx_ready, ev_txint, ev_rxint, core_rst, wide_mode, eoi_pulse;
    logic [7:0]  host_irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mbx_regs i_mbx_regs (
        .clk(clk), .rst(rst), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
        .h_wide(h_wide), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .c_tx_we(c_tx_we), .c_tx_state(c_tx_state), .c_rx_we(c_rx_we),
        .c_rx_state(c_rx_state), .c_data_we(c_data_we), .c_data(c_data),
        .data_q(data_q), .status_q(status_q), .rx_ready(rx_ready),
        .ev_txint(ev_txint), .ev_rxint(ev_rxint), .core_rst(core_rst),
        .wide_mode(wide_mode), .c_irq_req(c_irq_req), .eoi_pulse(eoi_pulse),
        .host_irq(host_irq)
    );

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hwr(logic [2:0] a, logic [15:0] d, logic wide);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wide = wide; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; h_wide = 1'b0;
    endtask

    task automatic hrd(logic [2:0] a, logic wide, output logic [15:0] d);
        @(negedge clk);
        h_addr = a; h_wide = wide; h_rd = 1'b1;
        #1 d = h_rdata;
        @(negedge clk);
        h_rd = 1'b0; h_wide = 1'b0;
    endtask

    task automatic core_rx(logic [2:0] s);
        @(negedge clk);
        c_rx_we = 1'b1; c_rx_state = s;
        @(negedge clk);
        c_rx_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        hrd(3'd0, 1'b0, d); check("R1", "data after reset", d, 16'h0);
        hrd(3'd2, 1'b0, d); check("R1", "status after reset", d, 16'h0);
        hrd(3'd4, 1'b0, d); check("R1", "control after reset", d, 16'h0);
        hrd(3'd6, 1'b0, d); check("R1", "route after reset", d, 16'h0);
        check("R1", "irq/events/hold after reset",
              {host_irq, 5'd0, ev_txint, ev_rxint, core_rst}, 16'h0);
    endtask

    task automatic t_data();
        logic [15:0] d;
        hwr(3'd0, 16'h00A5, 1'b0);
        hrd(3'd0, 1'b0, d); check("R2", "data low byte", d, 16'h00A5);
        hwr(3'd1, 16'h003C, 1'b0);
        hrd(3'd1, 1'b0, d); check("R2", "data high byte", d, 16'h003C);
        hwr(3'd0, 16'h1234, 1'b1);
        check("R10", "wide write without wide mode", data_q, 16'h3C34);
        hrd(3'd0, 1'b1, d); check("R10", "wide read without wide mode", d, 16'h0034);
        hwr(3'd4, 16'h0020, 1'b0);
        check("R6", "wide_mode follows bit 5", {15'd0, wide_mode}, 16'h1);
        hwr(3'd0, 16'hBEEF, 1'b1);
        check("R10", "wide write in wide mode", data_q, 16'hBEEF);
        hrd(3'd0, 1'b1, d); check("R10", "wide read in wide mode", d, 16'hBEEF);
        hwr(3'd4, 16'h0000, 1'b0);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        hwr(3'd4, 16'h00FF, 1'b0);
        check("R5", "both notify events on rise", {14'd0, ev_txint, ev_rxint}, 16'h3);
        check("R6", "core_rst on bit 4", {15'd0, core_rst}, 16'h1);
        @(negedge clk);
        check("R5", "events last one cycle", {14'd0, ev_txint, ev_rxint}, 16'h0);
        hrd(3'd4, 1'b0, d); check("R2", "control keeps bits 5:0", d, 16'h003F);
        hwr(3'd4, 16'h003F, 1'b0);
        check("R5", "no event on rewrite of 1", {14'd0, ev_txint, ev_rxint}, 16'h0);
        hwr(3'd4, 16'h003D, 1'b0);
        check("R5", "no event on clear", {14'd0, ev_txint, ev_rxint}, 16'h0);
        hwr(3'd4, 16'h003F, 1'b0);
        check("R5", "tx event only after clear-set", {14'd0, ev_txint, ev_rxint}, 16'h2);
        hwr(3'd4, 16'h0000, 1'b0);
        check("R6", "core_rst released", {15'd0, core_rst}, 16'h0);
    endtask

    task automatic t_status();
        logic [15:0] d;
        hwr(3'd2, 16'h0088, 1'b0);
        hrd(3'd2, 1'b0, d); check("R3", "host status flags", d, 16'h0088);
        core_rx(3'd6);
        check("R3", "core rx field keeps flags", {8'd0, status_q}, 16'h00E8);
        for (int s = 0; s < 8; s++) begin
            core_rx(3'(s));
            check("R4", $sformatf("rx_ready for code %0d", s), {15'd0, rx_ready},
                  {15'd0, (s == 1 || s == 5 || s == 6)});
        end
    endtask

    task automatic t_merge();
        hwr(3'd2, 16'h0000, 1'b0);
        @(negedge clk);
        h_addr = 3'd2; h_wdata = 16'h0003; h_wr = 1'b1;
        c_tx_we = 1'b1; c_tx_state = 3'd4; c_rx_we = 1'b1; c_rx_state = 3'd6;
        @(negedge clk);
        h_wr = 1'b0; c_tx_we = 1'b0; c_rx_we = 1'b0;
        check("R9", "host tx wins, core rx kept", {8'd0, status_q}, 16'h0063);
        @(negedge clk);
        h_wdata = 16'h0053; h_wr = 1'b1; c_tx_we = 1'b1; c_tx_state = 3'd2;
        @(negedge clk);
        h_wr = 1'b0; c_tx_we = 1'b0;
        check("R9", "host rx wins, core tx kept", {8'd0, status_q}, 16'h0052);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        hwr(3'd6, 16'h00FF, 1'b0);
        hrd(3'd6, 1'b0, d); check("R2", "route keeps bits 4 and 2:0", d, 16'h0017);
        @(negedge clk); c_irq_req = 1'b1;
        @(negedge clk); c_irq_req = 1'b0;
        check("R7", "line 7 driven", {8'd0, host_irq}, 16'h0080);
        hwr(3'd6, 16'h0003, 1'b0);
        check("R7", "disabled drives nothing", {8'd0, host_irq}, 16'h0000);
        hwr(3'd6, 16'h0013, 1'b0);
        check("R7", "pending survives disable, line 3", {8'd0, host_irq}, 16'h0008);
        hrd(3'd5, 1'b0, d);
        check("R8", "eoi read value", d, 16'h0000);
        check("R8", "eoi pulse and irq retired", {7'd0, eoi_pulse, host_irq}, 16'h0100);
        @(negedge clk);
        check("R8", "eoi pulse one cycle", {15'd0, eoi_pulse}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_data();
        t_ctrl();
        t_status();
        t_merge();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #20000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule